// File: doc/BRIEF.md
# Cartridge ROM/RAM bank mapper

This block sits between an 8-bit CPU bus and the ROM and RAM chips of a game cartridge. A CPU write into the lower 32 KiB of the address space does not reach memory. The block takes it as a write to one of four small control registers: the external-RAM gate, a 5-bit low ROM bank number, a 2-bit high bank number and a banking-mode flag. From these registers and the present CPU address, the block forms flat physical addresses for the ROM and the RAM in the same cycle.

Addresses below 0x4000 fall in a fixed ROM window. Addresses from 0x4000 to 0x7FFF fall in a switchable ROM window. The external RAM window is 8 KiB wide. Three static configuration inputs describe the cartridge: the ROM bank count as a power of two, the RAM organisation, and a multicart wiring option. The multicart option moves the high bank bits down by one position and drops bit 4 of the low bank register. A separate flag tells the memory side whether a RAM access reaches any storage at all.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the low bank register holds 1, the high register holds 0, the mode flag is 0 and RAM is gated off. A read at 0x4000 therefore maps to ROM byte 0x4000, and ram_mapped is 0.
- R2: A write with bus_addr[15:13]=000 enables RAM when bus_wdata[3:0]=0xA. Any other low nibble disables it. Bits 7:4 are ignored.
- R3: A write with bus_addr[15:13]=001 loads the low bank register from bus_wdata[4:0]. A value of 0 is stored as 1.
- R4: When cfg_multicart=1 at the time of the write, the value from R3 has its bit 4 cleared after the zero fix. Writing 0x10 therefore stores 0, and writing 0x00 stores 1. With cfg_multicart=1, the high register sits at bank bits 5:4 instead of 6:5.
- R5: A write with bus_addr[15:13]=010 loads the high register from bus_wdata[1:0]. A write with bus_addr[15:13]=011 loads the mode flag from bus_wdata[0]. Writes with bus_addr[15]=1 change no register.
- R6: For bus_addr in 0x4000–0x7FFF, rom_addr = ((low | high<<shift) mod 2^cfg_rom_log2) × 0x4000 + bus_addr[13:0]. The shift is 5, or 4 when cfg_multicart=1.
- R7: For bus_addr in 0x0000–0x3FFF, the ROM bank is 0 when the mode flag is 0. When the flag is 1, the bank is (high<<shift) mod 2^cfg_rom_log2. rom_addr = bank × 0x4000 + bus_addr[13:0].
- R8: ram_mapped is 1 only when RAM is enabled and cfg_ram_kind is not 0. The encoding is 0 = no RAM, 1 = 2 KiB, 2 = one 8 KiB bank, 3 = four 8 KiB banks.
- R9: With cfg_ram_kind=1, ram_addr = bus_addr[10:0], and the high register and mode flag have no effect.
- R10: With cfg_ram_kind of 2 or 3, ram_addr = bank × 0x2000 + bus_addr[12:0]. The bank is the high register when the mode flag is 1 and 0 otherwise, reduced modulo the bank count.
- R11: A register write takes effect at the rising edge on which bus_wr is sampled high. In the write cycle itself the outputs still reflect the old register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| cfg_rom_log2 | input | 3 | log2 of the ROM bank count (0–7) |
| cfg_ram_kind | input | 2 | RAM organisation code (see R8) |
| cfg_multicart | input | 1 | Multicart wiring option |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_mapped | output | 1 | RAM access reaches storage |

## Verification
A control-register write and an address translation can fall in the same cycle, because the write address is itself a ROM-window address that the translator maps. The bench provokes this on every write it issues: bus_wr, the register-select address and the data are held for one cycle, and the outputs are sampled before that cycle's rising edge. They are judged against a model that still holds the old register values. The bench then repeats reads at switchable, fixed and RAM addresses after the edge, to confirm that the new value, after the zero fix and the multicart masking, is what the translation uses.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    parameter int LO_W        = 5;
    parameter int HI_W        = 2;
    parameter int ROM_BANK_W  = 7;
    parameter int ROM_OFS_W   = 14;
    parameter int RAM_OFS_W   = 13;
    parameter int RAM_BANK_W  = HI_W;
    parameter int SMALL_OFS_W = 11;
    parameter int STD_SHIFT   = 5;
    parameter int MC_SHIFT    = 4;
    parameter int LOG2_W      = $clog2(ROM_BANK_W + 1);
    parameter int ROM_AW      = ROM_BANK_W + ROM_OFS_W;
    parameter int RAM_AW      = RAM_BANK_W + RAM_OFS_W;

    typedef enum logic [1:0] {
        RAM_NONE  = 2'd0,
        RAM_SMALL = 2'd1,
        RAM_ONE   = 2'd2,
        RAM_FOUR  = 2'd3
    } ram_kind_e;

    typedef enum logic [1:0] {
        SEL_GATE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_MODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            ram_en;
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic            mode;
    } bank_regs_t;
endpackage

// File: rtl/cbm_ctrl_regs.sv
module cbm_ctrl_regs
    import cbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       sel,
    input  logic [LO_W-1:0]  wdata,
    input  logic             multicart,
    output bank_regs_t       regs_q
);
    bank_regs_t      regs_d;
    logic [LO_W-1:0] lo_fix;
    reg_sel_e        which;

    assign which = reg_sel_e'(sel[1:0]);

    always_comb begin
        lo_fix = wdata;
        if (lo_fix == '0) lo_fix = LO_W'(1);
        if (multicart) lo_fix[LO_W-1] = 1'b0;

        regs_d = regs_q;
        if (wr && !sel[2]) begin
            unique case (which)
                SEL_GATE: regs_d.ram_en = (wdata[3:0] == 4'hA);
                SEL_LO:   regs_d.lo     = lo_fix;
                SEL_HI:   regs_d.hi     = wdata[HI_W-1:0];
                SEL_MODE: regs_d.mode   = wdata[0];
                default:  regs_d        = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.ram_en <= 1'b0;
            regs_q.lo     <= LO_W'(1);
            regs_q.hi     <= '0;
            regs_q.mode   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !sel[2]) |=> $stable(regs_q));

    // R3
    lo_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 3'b001 && !multicart) |=> (regs_q.lo != '0));

    // R4
    mc_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 3'b001 && multicart) |=> !regs_q.lo[LO_W-1]);

    // R2
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 3'b000 && wdata[3:0] != 4'hA) |=> !regs_q.ram_en);
endmodule

// File: rtl/cbm_rom_xlate.sv
module cbm_rom_xlate
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_regs_t        regs,
    input  logic [14:0]       addr,
    input  logic [LOG2_W-1:0] rom_log2,
    input  logic              multicart,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [ROM_BANK_W:0]   one_hot;
    logic [ROM_BANK_W:0]   mask_full;
    logic [ROM_BANK_W-1:0] mask;
    logic [ROM_BANK_W-1:0] hi_sh;
    logic [ROM_BANK_W-1:0] sw_bank;
    logic [ROM_BANK_W-1:0] fix_bank;
    logic [ROM_BANK_W-1:0] bank;

    always_comb begin
        one_hot   = (ROM_BANK_W + 1)'(1) << rom_log2;
        mask_full = one_hot - (ROM_BANK_W + 1)'(1);
        mask      = mask_full[ROM_BANK_W-1:0];
        hi_sh     = multicart ? (ROM_BANK_W'(regs.hi) << MC_SHIFT)
                              : (ROM_BANK_W'(regs.hi) << STD_SHIFT);
        sw_bank   = (ROM_BANK_W'(regs.lo) | hi_sh) & mask;
        fix_bank  = regs.mode ? (hi_sh & mask) : '0;
        bank      = addr[ROM_OFS_W] ? sw_bank : fix_bank;
        rom_addr  = {bank, addr[ROM_OFS_W-1:0]};
    end

    // R7
    fixed_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs.mode && !addr[ROM_OFS_W]) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] == '0));

    // R6
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_log2 == '0) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] == '0));
endmodule

// File: rtl/cbm_ram_xlate.sv
module cbm_ram_xlate
    import cbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  bank_regs_t           regs,
    input  logic [RAM_OFS_W-1:0] addr,
    input  logic [1:0]           kind_raw,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 ram_mapped
);
    ram_kind_e             kind;
    logic [RAM_BANK_W-1:0] sel_bank;

    assign kind = ram_kind_e'(kind_raw);

    always_comb begin
        sel_bank   = regs.mode ? regs.hi : '0;
        ram_mapped = regs.ram_en && (kind != RAM_NONE);
        unique case (kind)
            RAM_SMALL: ram_addr = RAM_AW'(addr[SMALL_OFS_W-1:0]);
            RAM_ONE:   ram_addr = RAM_AW'(addr);
            RAM_FOUR:  ram_addr = {sel_bank, addr};
            default:   ram_addr = '0;
        endcase
    end

    // R9
    small_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RAM_SMALL) |-> (ram_addr[RAM_AW-1:SMALL_OFS_W] == '0));

    // R10
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RAM_ONE) |-> (ram_addr[RAM_AW-1:RAM_OFS_W] == '0));

    // R8
    no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RAM_NONE) |-> !ram_mapped);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [LOG2_W-1:0] cfg_rom_log2,
    input  logic [1:0]        cfg_ram_kind,
    input  logic              cfg_multicart,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_mapped
);
    bank_regs_t regs_q;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[7:LO_W];

    cbm_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .sel       (bus_addr[15:13]),
        .wdata     (bus_wdata[LO_W-1:0]),
        .multicart (cfg_multicart),
        .regs_q    (regs_q)
    );

    cbm_rom_xlate u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .regs      (regs_q),
        .addr      (bus_addr[14:0]),
        .rom_log2  (cfg_rom_log2),
        .multicart (cfg_multicart),
        .rom_addr  (rom_addr)
    );

    cbm_ram_xlate u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs       (regs_q),
        .addr       (bus_addr[RAM_OFS_W-1:0]),
        .kind_raw   (cfg_ram_kind),
        .ram_addr   (ram_addr),
        .ram_mapped (ram_mapped)
    );

    // R5
    high_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15]) |=> $stable(regs_q));
endmodule

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [2:0]  cfg_rom_log2 = 3'd7;
    logic [1:0]  cfg_ram_kind = 2'd3;
    logic        cfg_multicart = 1'b0;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_mapped;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_en, m_lo, m_hi, m_mode;

    always #10 clk = ~clk;

    cart_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cfg_rom_log2(cfg_rom_log2),
        .cfg_ram_kind(cfg_ram_kind), .cfg_multicart(cfg_multicart),
        .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_mapped(ram_mapped)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h)", tag, act, exp, bus_addr);
        end
    endtask

    function automatic int exp_rom(input int a);
        int sh, cnt, bank;
        sh  = cfg_multicart ? 4 : 5;
        cnt = 1 << cfg_rom_log2;
        if (a >= 'h4000) begin
            bank = (m_lo | (m_hi << sh)) % cnt;
            return bank * 'h4000 + (a & 'h3FFF);
        end
        bank = m_mode ? ((m_hi << sh) % cnt) : 0;
        return bank * 'h4000 + a;
    endfunction

    task automatic compare(input bit wr);
        int a, nb, bank, exp_m;
        a = int'(bus_addr);
        if (a < 'h8000)
            chk(wr ? "R11" : (a >= 'h4000 ? "R6" : "R7"), int'(rom_addr), exp_rom(a));
        exp_m = (m_en != 0 && cfg_ram_kind != 0) ? 1 : 0;
        chk("R8", int'(ram_mapped), exp_m);
        if (exp_m == 1) begin
            if (cfg_ram_kind == 1) chk("R9", int'(ram_addr), a & 'h7FF);
            else begin
                nb   = (cfg_ram_kind == 3) ? 4 : 1;
                bank = (m_mode != 0 ? m_hi : 0) % nb;
                chk("R10", int'(ram_addr), bank * 'h2000 + (a & 'h1FFF));
            end
        end
    endtask

    task automatic model_write(input int a, input int d);
        int v;
        if (a >= 'h8000) return;
        case ((a >> 13) & 3)
            0: m_en = ((d & 'hF) == 'hA) ? 1 : 0;
            1: begin
                v = d & 'h1F;
                if (v == 0) v = 1;
                if (cfg_multicart) v = v & 'hF;
                m_lo = v;
            end
            2: m_hi = d & 3;
            default: m_mode = d & 1;
        endcase
    endtask

    task automatic step(input bit wr, input int a, input int d);
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = 16'(a);
        bus_wdata = 8'(d);
        #2;
        compare(wr);
        @(posedge clk);
        if (wr) model_write(a, d);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic sweep;
        for (int d = 0; d < 32; d++) begin
            step(1, 'h2000 + d * 3, d + (d << 5));
            step(0, 'h4000 + d * 97, 0);
            step(0, 'h7FFF - d, 0);
        end
        for (int h = 0; h < 4; h++) begin
            step(1, 'h4000 + h, h);
            for (int md = 0; md < 2; md++) begin
                step(1, 'h6000, md);
                step(0, 'h0123 + h, 0);
                step(0, 'h5555, 0);
                step(0, 'hA000 + h * 'h111, 0);
                step(0, 'hBFFF, 0);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_lo = 1; m_hi = 0; m_mode = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        step(0, 'h4000, 0);
        chk("R1", int'(rom_addr), 'h4000);
        chk("R1", int'(ram_mapped), 0);

        // R2 gate nibble
        step(1, 'h0000, 'h1A);
        step(0, 'hA010, 0);
        chk("R2", int'(ram_mapped), 1);
        step(1, 'h1FFF, 'h0B);
        step(0, 'hA010, 0);
        chk("R2", int'(ram_mapped), 0);
        step(1, 'h0000, 'h0A);

        // R3 zero becomes one
        step(1, 'h2000, 'h00);
        step(0, 'h4123, 0);
        chk("R3", int'(rom_addr), 'h4123);

        // R4 multicart masking and shift
        cfg_multicart = 1'b1;
        step(1, 'h3000, 'h10);
        step(0, 'h4000, 0);
        chk("R4", int'(rom_addr), 'h0000);
        step(1, 'h4000, 'h03);
        step(0, 'h4001, 0);
        chk("R4", int'(rom_addr), 'hC0001);

        // R5 write above 0x8000 ignored, then mode flag
        step(1, 'hA000, 'hFF);
        step(0, 'h4001, 0);
        chk("R5", int'(rom_addr), 'hC0001);
        step(1, 'h6000, 'h01);
        step(0, 'h0005, 0);
        chk("R5", int'(rom_addr), 'hC0005);
        step(0, 'hA004, 0);
        chk("R10", int'(ram_addr), 'h6004);

        // R9 small RAM ignores banking
        cfg_ram_kind = 2'd1;
        step(0, 'hBFFF, 0);
        chk("R9", int'(ram_addr), 'h7FF);

        for (int mc = 0; mc < 2; mc++) begin
            cfg_multicart = mc[0];
            for (int k = 0; k < 4; k++) begin
                cfg_ram_kind = 2'(k);
                cfg_rom_log2 = 3'((k == 0) ? 7 : (k == 1) ? 3 : (k == 2) ? 0 : 5);
                step(1, 'h0000, (k == 0) ? 'h05 : 'h0A);
                sweep();
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule